// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one burst of a synchronous DRAM read or write. A memory controller presents a start column, a three-bit burst length code, an ordering bit and a start pulse. From the next cycle on, the block emits one column address per clock with a valid flag, and marks the final beat with a last flag. The row and bank addresses presented with the start pulse are captured and held on the outputs for the whole burst.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that contains the start column. Two orderings are available. Linear ordering counts upward and discards the carry out of the block. Interleaved ordering XORs the beat number into the start column. A full-row burst counts linearly through the whole column space and wraps at the top. It has no natural end and runs until a stop input ends it. A new start pulse always takes precedence over the burst in flight.

Top module: `burst_col_seq`

## Requirements
- R1: Length codes 0, 1, 2 and 3 (in `len_code_i`) give bursts of exactly 1, 2, 4 and 8 beats. `valid_o` is high on consecutive cycles, and `last_o` is high only on the final beat. The first beat appears in the cycle after the start pulse is sampled.
- R2: With `order_i` = 0 (linear), beat k addresses the start column plus k, modulo the burst length, inside the aligned block. The bits above the block are kept. Example: 8 beats from 5 gives 5,6,7,0,1,2,3,4.
- R3: With `order_i` = 1 (interleaved), beat k addresses the start column XOR k. Example: 4 beats from 5 gives 5,4,7,6.
- R4: Length code 7 selects a full-row burst. The address increments by one per beat and wraps from 2^COL_W-1 to 0. `last_o` is never raised, and the burst continues until stopped.
- R5: A full-row burst requested with `order_i` = 1 runs in linear order.
- R6: For bursts of 1 or 2 beats, `order_i` has no effect on the addresses produced.
- R7: When the start column is a multiple of the burst length, both orderings produce ascending addresses.
- R8: Length codes 4, 5 and 6 give a single beat with `err_o` high on that beat. `err_o` is low at all other times.
- R9: `stop_i` sampled high during a beat lets that beat be delivered, and `valid_o` is low in the following cycle. `stop_i` while idle has no effect.
- R10: A start pulse during a burst abandons it. The next cycle carries beat 0 of the new burst. If start and stop arrive in the same cycle, start wins.
- R11: `row_o` and `bank_o` show the values captured with the start pulse and stay stable for the whole burst.
- R12: Reset (active-low, synchronous) leaves `valid_o`, `last_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a burst (sampled at rising edge) |
| stop_i | input | 1 | End the current burst after this beat |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 linear, 1 interleaved |
| row_i | input | ROW_W | Row address to carry with the burst |
| bank_i | input | BANK_W | Bank address to carry with the burst |
| col_o | output | COL_W | Column address of the current beat |
| row_o | output | ROW_W | Captured row address |
| bank_o | output | BANK_W | Captured bank address |
| valid_o | output | 1 | Beat valid |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Unsupported length code on this beat |

## Verification
Two functions can act on the same clock edge: the burst can end (by its last beat or by a stop) while a new start pulse is sampled. The bench provokes this by raising start together with stop partway through a burst, and by raising start on the last beat of another burst. It judges the result by requiring beat 0 of the new burst, with its own row and bank, in the very next cycle and no gap in `valid_o`. A further case stops a full-row burst right after it wraps, to confirm that the wrap and the stop do not disturb each other.

// File: rtl/bcs_pkg.sv
// Shared constants and types for the burst column sequencer.
// Assumes a three-bit length code.
package bcs_pkg;
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_t;

    localparam logic [2:0] LEN_ONE   = 3'd0;
    localparam logic [2:0] LEN_TWO   = 3'd1;
    localparam logic [2:0] LEN_FOUR  = 3'd2;
    localparam logic [2:0] LEN_EIGHT = 3'd3;
    localparam logic [2:0] LEN_ROW   = 3'd7;
endpackage

// File: rtl/bcs_len_decode.sv
// Decodes the burst length code into a block mask, a full-row flag,
// an error flag and the effective ordering.
// Assumes COL_W >= 3 so that an eight-beat block fits.
module bcs_len_decode
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       code_i,
    input  logic             order_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             bad_o,
    output order_t           ord_o
);
    // Map each code to the mask of its aligned block.
    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        bad_o  = 1'b0;
        unique case (code_i)
            LEN_ONE:   mask_o = COL_W'(0);
            LEN_TWO:   mask_o = COL_W'(1);
            LEN_FOUR:  mask_o = COL_W'(3);
            LEN_EIGHT: mask_o = COL_W'(7);
            LEN_ROW: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default: begin
                mask_o = COL_W'(0);
                bad_o  = 1'b1;
            end
        endcase
    end

    // A full-row burst is always linear.
    always_comb begin
        ord_o = (order_i && !full_o) ? ORD_XOR : ORD_LINEAR;
    end
endmodule

// File: rtl/bcs_addr_gen.sv
// Forms the column address of a beat from the captured start column,
// the beat number and the block mask. Purely combinational.
// Assumes cnt_i never exceeds mask_i.
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_t           ord_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    // Add the beat to the start column; the mask drops the carry out of the block.
    always_comb begin
        sum = base_i + cnt_i;
        if (ord_i == ORD_XOR) begin
            col_o = base_i ^ cnt_i;
        end else begin
            col_o = (base_i & ~mask_i) | (sum & mask_i);
        end
    end
endmodule

// File: rtl/bcs_beat_ctrl.sv
// Holds the burst state: active flag, beat counter and the settings
// captured at start. Start wins over stop and over the end of the burst.
// Assumes the decoded settings are valid in the cycle of the start pulse.
module bcs_beat_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    input  logic             bad_i,
    input  order_t           ord_i,
    output logic             active_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             bad_o,
    output order_t           ord_o,
    output logic             last_o
);
    logic full_q;

    // Final beat of a fixed-length burst.
    always_comb begin
        last_o = active_o && !full_q && (cnt_o == mask_o);
    end

    // Advance, finish or restart the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
            base_o   <= '0;
            mask_o   <= '0;
            full_q   <= 1'b0;
            bad_o    <= 1'b0;
            ord_o    <= ORD_LINEAR;
        end else if (start_i) begin
            active_o <= 1'b1;
            cnt_o    <= '0;
            base_o   <= base_i;
            mask_o   <= mask_i;
            full_q   <= full_i;
            bad_o    <= bad_i;
            ord_o    <= ord_i;
        end else if (active_o) begin
            if (stop_i || last_o) begin
                active_o <= 1'b0;
            end else begin
                cnt_o <= cnt_o + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
// Top of the burst column sequencer. Decodes the request, runs the
// beat counter, forms the address and carries row and bank along.
// Assumes inputs are synchronous to clk.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [2:0]        len_code_i,
    input  logic              order_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [COL_W-1:0]  col_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              err_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_bad;
    order_t           dec_ord;
    logic             active;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             bad_q;
    order_t           ord_q;
    logic             last_w;

    bcs_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i  (len_code_i),
        .order_i (order_i),
        .mask_o  (dec_mask),
        .full_o  (dec_full),
        .bad_o   (dec_bad),
        .ord_o   (dec_ord)
    );

    bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .base_i   (start_col_i),
        .mask_i   (dec_mask),
        .full_i   (dec_full),
        .bad_i    (dec_bad),
        .ord_i    (dec_ord),
        .active_o (active),
        .cnt_o    (cnt),
        .base_o   (base_q),
        .mask_o   (mask_q),
        .bad_o    (bad_q),
        .ord_o    (ord_q),
        .last_o   (last_w)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_i (base_q),
        .cnt_i  (cnt),
        .mask_i (mask_q),
        .ord_i  (ord_q),
        .col_o  (col_o)
    );

    // Capture row and bank with each start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_o  <= '0;
            bank_o <= '0;
        end else if (start_i) begin
            row_o  <= row_i;
            bank_o <= bank_i;
        end
    end

    // Drive the beat flags.
    always_comb begin
        valid_o = active;
        last_o  = last_w;
        err_o   = active && bad_q;
    end
endmodule

// File: rtl/bcs_checker.sv
// Temporal checks on the sequencer ports, attached by bind.
module bcs_checker #(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [COL_W-1:0]  col_o,
    input logic [ROW_W-1:0]  row_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              valid_o,
    input logic              last_o,
    input logic              err_o
);
    a_r12_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!valid_o && !last_o && !err_o));

    a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R2 and R3: both orderings flip bit 0 on every step
    a_r2_bit0_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i)) |-> (col_o[0] != $past(col_o[0])));

    a_r8_err_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (valid_o && last_o));

    a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    a_r10_start_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    a_r11_row_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i)) |-> ($stable(row_o) && $stable(bank_o)));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .col_o       (col_o),
    .row_o       (row_o),
    .bank_o      (bank_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
    localparam int COL_W  = 10;
    localparam int ROW_W  = 13;
    localparam int BANK_W = 2;
    localparam int COLS   = 1 << COL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              stop_i = 1'b0;
    logic [COL_W-1:0]  start_col_i = '0;
    logic [2:0]        len_code_i = '0;
    logic              order_i = 1'b0;
    logic [ROW_W-1:0]  row_i = '0;
    logic [BANK_W-1:0] bank_i = '0;
    logic [COL_W-1:0]  col_o;
    logic [ROW_W-1:0]  row_o;
    logic [BANK_W-1:0] bank_o;
    logic              valid_o;
    logic              last_o;
    logic              err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    burst_col_seq #(.COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_burst_col_seq (.*);

    always #2 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected beat count from the code; 0 marks full row.
    function automatic int beats_of(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    // Expected address of beat k.
    function automatic int exp_col(int s, int code, int ord, int k);
        int n = beats_of(code);
        if (n == 0) return (s + k) % COLS;
        if (ord == 1 && n > 2) return s ^ k;
        return (s - (s % n)) + ((s % n) + k) % n;
    endfunction

    task automatic issue(int s, int code, int ord, int row, int bank);
        start_i     = 1'b1;
        start_col_i = COL_W'(s);
        len_code_i  = 3'(code);
        order_i     = ord[0];
        row_i       = ROW_W'(row);
        bank_i      = BANK_W'(bank);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Run a burst and check every beat; stop_at < 0 lets it run to its end.
    task automatic run_burst(string req, int s, int code, int ord, int stop_at);
        int n = beats_of(code);
        int total = (stop_at >= 0) ? stop_at + 1 : n;
        int row = (s * 7 + 3) % (1 << ROW_W);
        int bank = s % (1 << BANK_W);
        issue(s, code, ord, row, bank);
        for (int k = 0; k < total; k++) begin
            check(req, "valid", int'(valid_o), 1);
            check(req, "col", int'(col_o), exp_col(s, code, ord, k));
            check(req, "last", int'(last_o), (n != 0 && k == n - 1) ? 1 : 0);
            check("R8", "err", int'(err_o), (code >= 4 && code <= 6) ? 1 : 0);
            check("R11", "row", int'(row_o), row);
            check("R11", "bank", int'(bank_o), bank);
            if (k == stop_at) stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
        end
        check(req, "valid after end", int'(valid_o), 0);
    endtask

    task automatic t_reset();
        check("R12", "valid", int'(valid_o), 0);
        check("R12", "last", int'(last_o), 0);
        check("R12", "err", int'(err_o), 0);
    endtask

    task automatic t_lengths();
        for (int c = 0; c < 4; c++) run_burst("R1", 9, c, 0, -1);
    endtask

    task automatic t_linear_wrap();
        int exp8 [8] = '{5, 6, 7, 0, 1, 2, 3, 4};
        issue(5, 3, 0, 1, 1);
        for (int k = 0; k < 8; k++) begin
            check("R2", "col 8 from 5", int'(col_o), exp8[k]);
            @(negedge clk);
        end
        run_burst("R2", 86, 2, 0, -1);
    endtask

    task automatic t_interleave();
        int exp4 [4] = '{5, 4, 7, 6};
        issue(5, 2, 1, 2, 2);
        for (int k = 0; k < 4; k++) begin
            check("R3", "col 4 from 5", int'(col_o), exp4[k]);
            @(negedge clk);
        end
        run_burst("R3", children(), 3, 1, -1);
    endtask

    function automatic int children();
        return 301;
    endfunction

    task automatic t_short_type();
        run_burst("R6", 7, 1, 1, -1);
        run_burst("R6", 7, 0, 1, -1);
        issue(3, 1, 1, 0, 0);
        check("R6", "len2 il beat0", int'(col_o), 3);
        @(negedge clk);
        check("R6", "len2 il beat1", int'(col_o), 2);
        @(negedge clk);
    endtask

    task automatic t_aligned();
        for (int o = 0; o < 2; o++) begin
            issue(40, 3, o, 0, 0);
            for (int k = 0; k < 8; k++) begin
                check("R7", "ascending", int'(col_o), 40 + k);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_full_row();
        run_burst("R4", COLS - 4, 7, 0, 9);
        run_burst("R5", 3, 7, 1, 5);
    endtask

    task automatic t_bad_codes();
        for (int c = 4; c < 7; c++) run_burst("R8", 22, c, 0, -1);
        check("R8", "err idle", int'(err_o), 0);
    endtask

    task automatic t_stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R9", "idle stop", int'(valid_o), 0);
        run_burst("R9", 16, 3, 0, 2);
        run_burst("R9", COLS - 1, 7, 0, 1);
    endtask

    task automatic t_restart();
        issue(2, 3, 0, 11, 1);
        @(negedge clk);
        // start and stop together: start wins
        stop_i = 1'b1;
        issue(13, 2, 1, 12, 3);
        stop_i = 1'b0;
        check("R10", "restart beat0", int'(col_o), 13);
        check("R10", "restart valid", int'(valid_o), 1);
        check("R11", "restart row", int'(row_o), 12);
        check("R11", "restart bank", int'(bank_o), 3);
        @(negedge clk);
        check("R10", "restart beat1", int'(col_o), 12);
        @(negedge clk);
        @(negedge clk);
        check("R10", "restart last", int'(last_o), 1);
        // start on the last beat: no gap
        issue(20, 0, 0, 5, 0);
        check("R10", "chained valid", int'(valid_o), 1);
        check("R10", "chained col", int'(col_o), 20);
        @(negedge clk);
        check("R10", "chained end", int'(valid_o), 0);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_lengths();
                t_linear_wrap();
                t_interleave();
                t_short_type();
                t_aligned();
                t_full_row();
                t_bad_codes();
                t_stop();
                t_restart();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule